// File: doc/BRIEF.md
# Version Blink Beacon

This block drives a status LED that shows two things at once: the design is running, and which build is loaded. It runs entirely from the board clock (40 MHz on the target board). A countdown prescaler gives a one-cycle tick enable every quarter second at the default reload value. A small sequencer advances only on those ticks and turns them into repeating groups of short blinks. Each blink is one tick lit followed by one tick dark. The number of blinks in a group equals a 4-bit version value taken from an input port. A longer dark pause separates the groups.

A version of zero gives a plain slow toggle with no grouping. The version value is captured only when a group begins, so a new value never cuts a group short. The same LED level is registered separately for each of several output pins, so the design can fan out to more than one LED. No derived or divided signal is used as a clock anywhere.

Top module: `version_beacon`

## Requirements
- R1: The prescaler produces exactly one tick every RELOAD+1 clock cycles. The LED changes level only on tick boundaries, and each lit blink lasts exactly RELOAD+1 cycles.
- R2: With version N in 1..15, a group consists of N blinks. Each blink is lit for one tick and then dark for one tick.
- R3: After the lit part of the last blink in a group, the LED stays dark for four ticks: the blink's own dark tick plus GAP_TICKS (default 3) extra dark ticks. The next group then begins.
- R4: With version 0, the LED is lit for one tick and dark for one tick, repeating, with no extra pause.
- R5: The version input is sampled only at the tick that starts a group. Changes at any other time do not alter the blink count of the group in progress.
- R6: The synchronous active-high reset holds every LED output low. After reset is released, the first blink of a group starts. The outputs go high on the second rising clock edge after release.
- R7: All LED outputs carry the same level in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Board clock; all state is clocked by it |
| rst | input | 1 | Synchronous active-high reset |
| version_i | input | VER_W | Blink count per group; 0 selects the slow toggle |
| led_o | output | PINS | Registered LED level, one identical copy per pin |

## Verification
A wrong prescaler count would show at the pins as a lit blink whose length is not RELOAD+1 cycles, on the very first blink. A sequencer that counts badly, samples the version at the wrong time, or shortens the pause would give a wrong sequence of lit and dark run lengths. That error appears within one group, at most 33 ticks. The bench therefore measures every run of constant LED level and compares it against the run list derived from the version schedule. It also moves the version input to a decoy value partway through each group to expose sampling outside the group start.

// File: rtl/beacon_pkg.sv
package beacon_pkg;

    typedef enum logic [2:0] {
        ST_ARM  = 3'd0,
        ST_ON   = 3'd1,
        ST_OFF  = 3'd2,
        ST_GAP  = 3'd3,
        ST_SLOW = 3'd4
    } beacon_st_e;

endpackage

// File: rtl/beacon_prescaler.sv
module beacon_prescaler #(
    parameter int RELOAD = 10_000_000,
    localparam int CNT_W = $clog2(RELOAD + 1)
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (pre_q.cnt == '0) begin
            pre_d.cnt = RELOAD_V;
        end else begin
            pre_d.cnt = pre_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign tick_o = (pre_q.cnt == '0);

    // R1: a tick is a single-cycle enable, never held
    p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/beacon_sequencer.sv
module beacon_sequencer
    import beacon_pkg::*;
#(
    parameter int VER_W     = 4,
    parameter int GAP_TICKS = 3,
    localparam int GAP_W    = (GAP_TICKS > 2) ? $clog2(GAP_TICKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [VER_W-1:0] version_i,
    output logic             lit_o
);

    typedef struct packed {
        beacon_st_e       st;
        logic [VER_W-1:0] left;
        logic [GAP_W-1:0] gap;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (tick_i) begin
            unique case (seq_q.st)
                ST_ARM: begin
                    if (version_i == '0) begin
                        seq_d.st = ST_SLOW;
                    end else begin
                        seq_d.st   = ST_ON;
                        seq_d.left = version_i;
                    end
                end
                ST_SLOW: seq_d.st = ST_ARM;
                ST_ON:   seq_d.st = ST_OFF;
                ST_OFF: begin
                    if (seq_q.left == VER_W'(1)) begin
                        seq_d.st  = ST_GAP;
                        seq_d.gap = GAP_W'(GAP_TICKS - 1);
                    end else begin
                        seq_d.left = seq_q.left - 1'b1;
                        seq_d.st   = ST_ON;
                    end
                end
                ST_GAP: begin
                    if (seq_q.gap == GAP_W'(1)) begin
                        seq_d.st = ST_ARM;
                    end else begin
                        seq_d.gap = seq_q.gap - 1'b1;
                    end
                end
                default: seq_d.st = ST_ARM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: ST_ARM, left: '0, gap: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign lit_o = (seq_q.st == ST_ON) || (seq_q.st == ST_SLOW);

    // R1: the sequencer only moves on a tick
    p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(seq_q));

    // R2: inside a group the remaining blink count is never zero
    p_dot_count_live_r2: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == ST_ON || seq_q.st == ST_OFF) |-> seq_q.left != '0);

    // R3: the pause counter stays in its legal range
    p_gap_range_r3: assert property (@(posedge clk) disable iff (rst)
        seq_q.st == ST_GAP |-> (seq_q.gap != '0 && int'(seq_q.gap) < GAP_TICKS));

    // R4: a slow-toggle lit tick is always followed by a group start
    p_slow_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == ST_SLOW && tick_i) |=> seq_q.st == ST_ARM);

    // R5: within a group the remaining count never grows
    p_no_reload_mid_group_r5: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == ST_ON || seq_q.st == ST_OFF) |=> seq_q.left <= $past(seq_q.left));

endmodule

// File: rtl/beacon_fanout.sv
module beacon_fanout #(
    parameter int PINS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lit_i,
    output logic [PINS-1:0] led_o
);

    logic [PINS-1:0] led_d, led_q;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign led_d[i] = lit_i;

        always_ff @(posedge clk) begin
            if (rst) begin
                led_q[i] <= 1'b0;
            end else begin
                led_q[i] <= led_d[i];
            end
        end

        // R7: every pin follows the sequencer level one cycle later
        p_pin_follow_r7: assert property (@(posedge clk) disable iff (rst)
            !rst |=> led_q[i] == $past(lit_i));
    end

    assign led_o = led_q;

endmodule

// File: rtl/version_beacon.sv
module version_beacon #(
    parameter int RELOAD    = 10_000_000,
    parameter int VER_W     = 4,
    parameter int GAP_TICKS = 3,
    parameter int PINS      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VER_W-1:0] version_i,
    output logic [PINS-1:0]  led_o
);

    logic tick;
    logic lit;

    beacon_prescaler #(
        .RELOAD(RELOAD)
    ) u_prescaler (
        .clk   (clk),
        .rst   (rst),
        .tick_o(tick)
    );

    beacon_sequencer #(
        .VER_W    (VER_W),
        .GAP_TICKS(GAP_TICKS)
    ) u_sequencer (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .version_i(version_i),
        .lit_o    (lit)
    );

    beacon_fanout #(
        .PINS(PINS)
    ) u_fanout (
        .clk  (clk),
        .rst  (rst),
        .lit_i(lit),
        .led_o(led_o)
    );

    // R6: the outputs are dark in the cycle after reset is seen
    p_dark_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> led_o == '0);

endmodule

// File: tb/tb_version_beacon.sv
module tb_version_beacon;

    localparam int RELOAD = 4;
    localparam int P      = RELOAD + 1;
    localparam int PINS   = 3;
    localparam int NGRP   = 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      ver = 4'd0;
    logic [PINS-1:0] led;

    int checks = 0;
    int fails  = 0;
    int pc     = 0;
    bit done   = 1'b0;

    typedef struct {
        bit    lvl;
        int    len;
        string req;
    } run_t;

    run_t exp_q[$];
    int   vers[NGRP+1] = '{3, 1, 0, 0, 15, 2, 5, 4};

    always #5 clk = ~clk;

    version_beacon #(
        .RELOAD   (RELOAD),
        .VER_W    (4),
        .GAP_TICKS(3),
        .PINS     (PINS)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .version_i(ver),
        .led_o    (led)
    );

    always @(posedge clk) begin
        if (!rst) pc <= pc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push_run(input bit lvl, input int len, input string req);
        run_t r;
        r.lvl = lvl;
        r.len = len;
        r.req = req;
        exp_q.push_back(r);
    endtask

    task automatic wait_pc(input int n);
        while (pc < n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Scoreboard monitor: measures runs of constant LED level
    bit started = 1'b0;
    bit cur     = 1'b0;
    int len     = 0;

    always @(negedge clk) begin
        if (!rst) begin
            check(led == {PINS{led[0]}}, "R7", int'(led), int'({PINS{led[0]}}));
            if (!started) begin
                if (led[0]) begin
                    started = 1'b1;
                    cur     = 1'b1;
                    len     = 1;
                end
            end else if (led[0] == cur) begin
                len++;
            end else begin
                if (exp_q.size() != 0) begin
                    run_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (e.lvl != cur || e.len != len) begin
                        fails++;
                        $display("FAIL %s: run level %0d length %0d, expected level %0d length %0d",
                                 e.req, cur, len, e.lvl, e.len);
                    end
                end
                cur = led[0];
                len = 1;
            end
        end
    end

    // Driver
    initial begin
        int t;
        int tstart[NGRP+1];
        t = 0;
        for (int g = 0; g < NGRP; g++) begin
            int v;
            v = vers[g];
            tstart[g] = t;
            if (v == 0) begin
                push_run(1'b1, P, "R4");
                push_run(1'b0, P, "R4");
                t += 2;
            end else begin
                for (int d = 1; d <= v; d++) begin
                    push_run(1'b1, P, (g == 0) ? "R1" : "R5");
                    push_run(1'b0, (d == v) ? 4 * P : P, (d == v) ? "R3" : "R2");
                end
                t += 2 * v + 3;
            end
        end
        tstart[NGRP] = t;

        ver = 4'(vers[0]);
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(led == '0, "R6", int'(led), 0);
        rst = 1'b0;
        @(negedge clk);
        check(led == '0, "R6", int'(led), 0);
        @(negedge clk);
        check(led == {PINS{1'b1}}, "R6", int'(led), int'({PINS{1'b1}}));

        // R5: decoy value mid-group, then the real next version
        for (int g = 0; g < NGRP; g++) begin
            wait_pc(tstart[g] * P + 2);
            ver = 4'(~vers[g+1]);
            wait_pc(tstart[g] * P + P + 2);
            ver = 4'(vers[g+1]);
        end

        while (exp_q.size() != 0) @(negedge clk);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d runs pending expected 0", exp_q.size());
        finish_run();
    end

endmodule